// File: doc/BRIEF.md
# Two-Stage Reciprocal-Table Fixed-Point Divider

This block divides one signed 16-bit fixed-point operand by another and returns the quotient in the same format. Each value is two's complement with 9 fractional bits, so the integer value 512 stands for 1.0. It serves the processing elements of a square-root-free rotation array, where every element needs a quotient on each cycle and a long iterative divider would stall the array.

The divisor magnitude is first shifted left until its top bit is set. The normalized value is split into an upper byte `H` and a lower byte `L`. A 256-entry table of 8-bit factors, indexed by `H`, supplies a scaled `1/H²`. The reciprocal then follows from the first-order expansion `1/(H·256+L) ≈ (H·256−L)/(H·256)²`. In the first stage the block normalizes the divisor, reads the table and forms `H·256−L`. In the second stage it multiplies by the dividend magnitude and the table factor, undoes the normalizing shift, rounds, restores the sign and saturates.

Both ends are valid/ready streams. An input pair is taken on a rising edge when `in_valid` and `in_ready` are both high. A result leaves when `out_valid` and `out_ready` are both high. When `out_ready` is low while a result is waiting, the whole pipeline freezes: `in_ready` drops, and no data are lost or reordered.

Top module: `taylor_div`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With `out_ready` high, a pair accepted on a rising edge has its result on the outputs, with `out_valid` high, right after the following rising edge.
- R3: With `out_ready` held high, `in_ready` stays high, so one pair is accepted every cycle. Every accepted pair yields exactly one result, in order.
- R4: For a nonzero divisor whose quotient is in range, let `m` be the divisor magnitude shifted left until bit 15 is set, with `H = m[15:8]` and `L = m[7:0]`. Let `T = min(255, round(2^22/H²))`. Then `|q − exact| ≤ |exact|·((L/(H·256))² + |T−2^22/H²|/(2^22/H²)) + 1 LSB`.
- R5: The quotient is negative exactly when the operand signs differ, and positive when they agree, whenever the exact quotient magnitude is at least 1 LSB.
- R6: A quotient above the range gives 0x7FFF and one below gives 0x8000. `out_div0` stays low in both cases.
- R7: A zero divisor gives 0x7FFF for a dividend of zero or above and 0x8000 for a negative dividend, with `out_div0` high for that result only.
- R8: While `out_valid` is high and `out_ready` is low, `out_quot` and `out_div0` hold, `in_ready` is low, and no accepted pair is lost.
- R9: Divisors of any magnitude, down to 1 LSB, meet R4 through the normalizing shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_dividend | input | 16 | Dividend, signed, 9 fractional bits |
| in_divisor | input | 16 | Divisor, signed, 9 fractional bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_quot | output | 16 | Quotient, signed, 9 fractional bits |
| out_div0 | output | 1 | Result came from a zero divisor |

## Verification
The bench goes after the operand values where a shift or sign error shows up at once. These are a 1-LSB divisor, which a missing or short normalizing shift would turn into a wildly wrong quotient, and the most negative divisor and dividend, where a wrong magnitude would flip the sign. It also drives quotients just past the range in both directions. A design with a lost saturation would wrap there, and a swapped limit would return 0x7FFF for a negative quotient. Zero divisors with positive, zero and negative dividends catch a flag that sticks or a saturation that ignores the dividend's sign. A stalled consumer exposes a pipeline that keeps advancing, which would show as changed outputs or dropped results.

// File: rtl/taylor_div_pkg.sv
package taylor_div_pkg;

  // Scaled reciprocal-square table entry: round(2^(2*half_w+lut_w-2) / xh^2),
  // clamped to the entry width. Index zero is never used after normalization.
  function automatic longint unsigned recip_entry(longint unsigned xh,
                                                  longint unsigned half_w,
                                                  longint unsigned lut_w);
    longint unsigned top;
    longint unsigned sq;
    longint unsigned num;
    longint unsigned val;
    top = (64'd1 << lut_w) - 64'd1;
    if (xh == 0) return top;
    sq  = xh * xh;
    num = 64'd1 << (2 * half_w + lut_w - 2);
    val = (num + sq / 2) / sq;
    if (val > top) val = top;
    return val;
  endfunction

endpackage

// File: rtl/tdiv_lzc.sv
module tdiv_lzc #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          is_zero
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end

  assign is_zero = (vec == '0);
endmodule

// File: rtl/tdiv_rom.sv
module tdiv_rom #(
  parameter int HALF_W = 8,
  parameter int LUT_W  = 8,
  localparam int DEPTH = 1 << HALF_W
) (
  input  logic [HALF_W-1:0] addr,
  output logic [LUT_W-1:0]  data
);
  import taylor_div_pkg::*;

  logic [LUT_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = LUT_W'(recip_entry(longint'(g), longint'(HALF_W), longint'(LUT_W)));
  end

  assign data = tbl[addr];
endmodule

// File: rtl/tdiv_front.sv
module tdiv_front #(
  parameter int DATA_W = 16,
  parameter int LUT_W  = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int CW     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] mag_a,
  output logic [DATA_W-1:0] diff,
  output logic [LUT_W-1:0]  tfac,
  output logic [CW-1:0]     shamt,
  output logic              neg,
  output logic              zero
);
  logic [DATA_W-1:0] mag_d;
  logic [DATA_W-1:0] norm;
  logic [HALF_W-1:0] xh;
  logic [HALF_W-1:0] xl;

  assign mag_a = dividend[DATA_W-1] ? (DATA_W'(0) - dividend) : dividend;
  assign mag_d = divisor[DATA_W-1]  ? (DATA_W'(0) - divisor)  : divisor;
  assign neg   = dividend[DATA_W-1] ^ divisor[DATA_W-1];

  tdiv_lzc #(.W(DATA_W)) u_lzc (
    .vec    (mag_d),
    .count  (shamt),
    .is_zero(zero)
  );

  assign norm = mag_d << shamt;
  assign xh   = norm[DATA_W-1 -: HALF_W];
  assign xl   = norm[HALF_W-1:0];
  assign diff = {xh, {HALF_W{1'b0}}} - DATA_W'(xl);

  tdiv_rom #(.HALF_W(HALF_W), .LUT_W(LUT_W)) u_rom (
    .addr(xh),
    .data(tfac)
  );

  // R9
  norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |-> norm[DATA_W-1]);
endmodule

// File: rtl/tdiv_back.sv
module tdiv_back #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 9,
  parameter int LUT_W  = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int CW     = $clog2(DATA_W + 1),
  localparam int P_W    = 2 * DATA_W + LUT_W,
  localparam int WIDE_W = P_W + DATA_W,
  localparam int SHIFT  = 4 * HALF_W + LUT_W - 2 - FRAC_W
) (
  input  logic [DATA_W-1:0] mag_a,
  input  logic [DATA_W-1:0] diff,
  input  logic [LUT_W-1:0]  tfac,
  input  logic [CW-1:0]     shamt,
  input  logic              neg,
  input  logic              zero,
  output logic [DATA_W-1:0] quot,
  output logic              div0
);
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [P_W-1:0]    prod;
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] mag;
  logic [DATA_W-1:0] lim;
  logic [DATA_W-1:0] sat;

  assign prod = P_W'(mag_a) * P_W'(diff) * P_W'(tfac);
  assign wide = (WIDE_W'(prod) << shamt) + (WIDE_W'(1) << (SHIFT - 1));
  assign mag  = wide >> SHIFT;
  assign lim  = neg ? NEG_LIM : POS_LIM;
  assign sat  = (zero || (mag > WIDE_W'(lim))) ? lim : mag[DATA_W-1:0];
  assign quot = neg ? (DATA_W'(0) - sat) : sat;
  assign div0 = zero;
endmodule

// File: rtl/taylor_div.sv
module taylor_div #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 9,
  parameter int LUT_W  = 8,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_dividend,
  input  logic [DATA_W-1:0] in_divisor,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_quot,
  output logic              out_div0
);
  logic              pipe_en;
  logic [DATA_W-1:0] f_mag_a, f_diff;
  logic [LUT_W-1:0]  f_tfac;
  logic [CW-1:0]     f_sh;
  logic              f_neg, f_zero;

  logic              s1_v;
  logic [DATA_W-1:0] s1_mag_a, s1_diff;
  logic [LUT_W-1:0]  s1_tfac;
  logic [CW-1:0]     s1_sh;
  logic              s1_neg, s1_zero;

  logic [DATA_W-1:0] b_quot;
  logic              b_div0;

  assign pipe_en  = !out_valid || out_ready;
  assign in_ready = pipe_en;

  tdiv_front #(.DATA_W(DATA_W), .LUT_W(LUT_W)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .dividend(in_dividend),
    .divisor (in_divisor),
    .mag_a   (f_mag_a),
    .diff    (f_diff),
    .tfac    (f_tfac),
    .shamt   (f_sh),
    .neg     (f_neg),
    .zero    (f_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_mag_a <= '0;
      s1_diff  <= '0;
      s1_tfac  <= '0;
      s1_sh    <= '0;
      s1_neg   <= 1'b0;
      s1_zero  <= 1'b0;
    end else if (pipe_en) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_mag_a <= f_mag_a;
        s1_diff  <= f_diff;
        s1_tfac  <= f_tfac;
        s1_sh    <= f_sh;
        s1_neg   <= f_neg;
        s1_zero  <= f_zero;
      end
    end
  end

  tdiv_back #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .LUT_W(LUT_W)) u_back (
    .mag_a(s1_mag_a),
    .diff (s1_diff),
    .tfac (s1_tfac),
    .shamt(s1_sh),
    .neg  (s1_neg),
    .zero (s1_zero),
    .quot (b_quot),
    .div0 (b_div0)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_quot  <= '0;
      out_div0  <= 1'b0;
    end else if (pipe_en) begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_quot <= b_quot;
        out_div0 <= b_div0;
      end
    end
  end

  // R2
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_v);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quot) && $stable(out_div0));

  // R7
  div0_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_div0 |->
      (out_quot == {1'b0, {(DATA_W-1){1'b1}}} || out_quot == {1'b1, {(DATA_W-1){1'b0}}}));
endmodule

// File: tb/test_taylor_div.sv
module test_taylor_div;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  // {dividend, divisor}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0200_0200, 32'h0600_0200, 32'h0200_0600, 32'hFE00_0400,
    32'hF000_FC00, 32'h1234_0357, 32'h7FFF_7FFF, 32'h8000_8000,
    32'h0001_0001, 32'h4000_0100, 32'hC000_0100, 32'h7FFF_0001,
    32'h8000_0001, 32'h0000_1234, 32'h0155_01FF, 32'h2AAA_FF01,
    32'h0300_0000, 32'hFF00_0000, 32'h0000_0000
  };

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [15:0] in_a = 0;
  logic [15:0] in_d = 0;
  logic out_valid;
  logic out_ready = 1;
  logic [15:0] out_quot;
  logic out_div0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit lat_mode = 0;
  bit done = 0;

  logic signed [15:0] q_a [64];
  logic signed [15:0] q_d [64];
  int q_acc [64];
  int wr = 0;
  int rd = 0;
  bit stall_prev = 0;
  logic [15:0] prev_q;
  logic prev_z;

  taylor_div i_taylor_div (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_a), .in_divisor(in_d),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quot(out_quot), .out_div0(out_div0)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_result();
    int a, d, q, m, xh, xl, tq, expq;
    real qe, ce, e1, ti, e2, tol, dif;
    a = int'(q_a[rd]);
    d = int'(q_d[rd]);
    q = int'($signed(out_quot));
    if (lat_mode) chk(cyc - q_acc[rd] == 1, "R2 latency", cyc - q_acc[rd], 1);
    if (d == 0) begin
      expq = (a < 0) ? -32768 : 32767;
      chk(q == expq, "R7 zero-divisor quotient", q, expq);
      chk(out_div0 == 1'b1, "R7 zero-divisor flag", int'(out_div0), 1);
      return;
    end
    chk(out_div0 == 1'b0, "R7 flag low for nonzero divisor", int'(out_div0), 0);
    m = (d < 0) ? -d : d;
    while (m < 32768) m = m * 2;
    xh = m / 256;
    xl = m % 256;
    ti = 4194304.0 / (real'(xh) * real'(xh));
    tq = $rtoi(ti + 0.5);
    if (tq > 255) tq = 255;
    e1 = (real'(xl) / (real'(xh) * 256.0)) ** 2;
    e2 = (real'(tq) > ti ? real'(tq) - ti : ti - real'(tq)) / ti;
    qe = real'(a) / real'(d) * 512.0;
    ce = qe > 32767.0 ? 32767.0 : (qe < -32768.0 ? -32768.0 : qe);
    tol = (qe < 0 ? -qe : qe) * (e1 + e2) * 1.05 + 1.0;
    dif = real'(q) - ce;
    if (dif < 0) dif = -dif;
    if (qe > 32767.0 || qe < -32768.0)
      chk(dif <= tol, "R6 saturation", q, $rtoi(ce));
    else if (((d < 0) ? -d : d) < 256)
      chk(dif <= tol, "R9 small divisor", q, $rtoi(ce));
    else
      chk(dif <= tol, "R4 accuracy", q, $rtoi(ce));
    if (qe >= 1.0) chk(q > 0, "R5 positive sign", q, $rtoi(ce));
    if (qe <= -1.0) chk(q < 0, "R5 negative sign", q, $rtoi(ce));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R8 in_ready low during stall", int'(in_ready), 0);
        if (stall_prev) begin
          chk(out_quot == prev_q, "R8 quotient held", int'(out_quot), int'(prev_q));
          chk(out_div0 == prev_z, "R8 flag held", int'(out_div0), int'(prev_z));
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_q = out_quot;
      prev_z = out_div0;
      if (out_valid && out_ready) begin
        if (rd < wr) check_result();
        else chk(1'b0, "R3 unexpected result", 1, 0);
        rd++;
      end
      if (in_valid && in_ready && wr < 64) begin
        q_a[wr] = in_a;
        q_d[wr] = in_d;
        q_acc[wr] = cyc + 1;
        wr++;
      end
    end
  end

  task automatic send(input logic [15:0] a, input logic [15:0] d, input bit must_ready);
    in_valid = 1;
    in_a = a;
    in_d = d;
    @(negedge clk);
    if (must_ready) chk(in_ready, "R3 in_ready during stream", int'(in_ready), 1);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    @(posedge clk);
    #1;

    // Streaming pass through the vector table, one pair per cycle.
    lat_mode = 1;
    for (int i = 0; i < NVEC; i++) send(VEC[i][31:16], VEC[i][15:0], 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd == NVEC && wr == NVEC, "R3 one result per pair", rd, NVEC);

    // Consumer stall with the pipeline full.
    lat_mode = 0;
    @(posedge clk);
    #1 out_ready = 0;
    send(16'h0A00, 16'h0300, 1'b0);
    send(16'h0100, 16'h0700, 1'b0);
    fork
      send(16'hF300, 16'h0500, 1'b0);
      begin
        repeat (6) @(posedge clk);
        #1 out_ready = 1;
      end
    join
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd == NVEC + 3 && wr == NVEC + 3, "R8 no result lost after stall", rd, NVEC + 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule